// File: doc/BRIEF.md
# Receptive-Field Spike Delay Encoder

This block turns one unsigned input sample into a burst of timed events for a spiking network front end. Sixteen input neurons each own a triangular receptive field. The field centres are evenly spaced over the input range. When a sample arrives, the block looks up a firing delay for all sixteen neurons in a single table read. Each neuron then counts its delay down inside a sixteen-step frame and emits exactly one spike.

A neuron whose centre sits on the sample fires at step 0. Neurons that are further away fire later. Neurons outside their field fire on the last step of the frame. With the default field layout a typical sample activates four or five neurons before the last step.

A start strobe with the sample launches a frame. The frame step number, an active flag and a last-step pulse are driven out beside the spike vector. A strobe that arrives while a frame is pending or running is ignored.

Top module: `rf_spike_encoder`

## Requirements
- R1: During reset and after it, before any start, the spike vector, the step number, the active flag and the last-step pulse are all 0.
- R2: A start strobe taken while the block is idle latches the value in that cycle. The active flag rises with step 0 on the second rising edge after the strobe edge. At the first edge the table word is registered, and at the second the frame begins.
- R3: Neuron k (spike bit k, k = 0..15) fires at step min(15, round(2·d/5)). Here d = |x − c_k| and the centre is c_k = 37 + 17·k. The rounding is to the nearest integer, and no ties can occur.
- R4: In every frame each of the 16 neurons raises its spike bit in exactly one cycle. A neuron outside its field fires at step 15.
- R5: For the input 25, bit 0 fires at step 5, bit 1 fires at step 12, and bits 2..15 fire at step 15.
- R6: An input equal to a neuron's centre makes that neuron fire at step 0.
- R7: A start strobe while a read is pending or a frame is active is ignored. Spike timing follows the original value, and no further frame follows.
- R8: The last-step pulse is high for exactly one cycle per frame, the cycle at step 15. The active flag is low in the next cycle.
- R9: While active, the step number runs 0, 1, …, 15 over consecutive cycles.
- R10: No spike bit is high while the active flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe for a new frame |
| value_i | input | 8 | Input sample, taken with an accepted strobe |
| spike_o | output | 16 | One bit per neuron, high in its firing step |
| step_o | output | 4 | Current step inside the frame |
| frame_active_o | output | 1 | High during the 16 frame steps |
| frame_done_o | output | 1 | High on step 15 of a frame |

## Verification
Every one of the 256 input values is encoded. Each neuron's firing step is compared with the field formula, which separates a wrong centre, slope, rounding or cap from a correct one. The same sweep shows that each neuron fires once per frame. Value 0 lies outside every field and checks that all neurons fall back to the last step. Each centre value and the value 25 pin down the step-0 optimum and the two-neuron pattern. Strobes held into the read cycle and pulsed mid-frame show that a busy block neither restarts nor retimes its spikes, and that no frame follows afterwards.

// File: rtl/rfse_pkg.sv
package rfse_pkg;

  typedef enum logic [1:0] {
    NRN_IDLE = 2'd0,
    NRN_WAIT = 2'd1,
    NRN_DONE = 2'd2
  } nrn_state_t;

  // Firing delay of neuron k for input x: distance to the field centre,
  // scaled by num/den with rounding, capped at dmax.
  function automatic int rf_delay(input int x, input int k, input int c0,
                                  input int sp, input int num, input int den,
                                  input int dmax);
    int c;
    int d;
    int v;
    c = c0 + k * sp;
    d = (x > c) ? (x - c) : (c - x);
    v = (d * num + den / 2) / den;
    if (v > dmax) v = dmax;
    return v;
  endfunction

endpackage

// File: rtl/rfse_delay_rom.sv
module rfse_delay_rom #(
  parameter int IN_W    = 8,
  parameter int N_NEUR  = 16,
  parameter int DLY_W   = 4,
  parameter int CENTRE0 = 37,
  parameter int SPACING = 17,
  parameter int SLOPE_N = 2,
  parameter int SLOPE_D = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_en,
  input  logic [IN_W-1:0]           addr,
  output logic [N_NEUR*DLY_W-1:0]   rd_word
);
  import rfse_pkg::*;

  localparam int DEPTH  = 1 << IN_W;
  localparam int WORD_W = N_NEUR * DLY_W;
  localparam int DMAX   = (1 << DLY_W) - 1;

  function automatic logic [DEPTH*WORD_W-1:0] build_image();
    logic [DEPTH*WORD_W-1:0] img;
    img = '0;
    for (int a = 0; a < DEPTH; a++) begin
      for (int k = 0; k < N_NEUR; k++) begin
        img[a*WORD_W + k*DLY_W +: DLY_W] =
          DLY_W'(rf_delay(a, k, CENTRE0, SPACING, SLOPE_N, SLOPE_D, DMAX));
      end
    end
    return img;
  endfunction

  localparam logic [DEPTH*WORD_W-1:0] IMAGE = build_image();

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_word <= '0;
    end else if (rd_en) begin
      rd_word <= IMAGE[int'(addr)*WORD_W +: WORD_W];
    end
  end

endmodule

// File: rtl/rfse_frame_ctrl.sv
module rfse_frame_ctrl #(
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              accept_o,
  output logic              rd_valid_o,
  output logic              active_o,
  output logic [STEP_W-1:0] step_o,
  output logic              done_o
);
  localparam logic [STEP_W-1:0] LAST = {STEP_W{1'b1}};

  logic              rd_valid_q;
  logic              active_q;
  logic [STEP_W-1:0] step_q;

  assign accept_o   = start_i && !rd_valid_q && !active_q;
  assign rd_valid_o = rd_valid_q;
  assign active_o   = active_q;
  assign step_o     = step_q;
  assign done_o     = active_q && (step_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      active_q   <= 1'b0;
      step_q     <= '0;
    end else begin
      rd_valid_q <= accept_o;
      if (rd_valid_q) begin
        active_q <= 1'b1;
        step_q   <= '0;
      end else if (active_q) begin
        if (step_q == LAST) begin
          active_q <= 1'b0;
          step_q   <= '0;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rfse_neuron.sv
module rfse_neuron #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic             tick_i,
  output logic             spike_o
);
  import rfse_pkg::*;

  nrn_state_t       st_q;
  logic [DLY_W-1:0] cnt_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign spike_o = tick_i && (st_q == NRN_WAIT) && at_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= NRN_IDLE;
      cnt_q <= '0;
    end else if (load_i) begin
      st_q  <= NRN_WAIT;
      cnt_q <= delay_i;
    end else if (tick_i && st_q == NRN_WAIT) begin
      if (at_zero) begin
        st_q <= NRN_DONE;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/rf_spike_encoder.sv
module rf_spike_encoder #(
  parameter int IN_W    = 8,
  parameter int N_NEUR  = 16,
  parameter int DLY_W   = 4,
  parameter int CENTRE0 = 37,
  parameter int SPACING = 17,
  parameter int SLOPE_N = 2,
  parameter int SLOPE_D = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [IN_W-1:0]   value_i,
  output logic [N_NEUR-1:0] spike_o,
  output logic [DLY_W-1:0]  step_o,
  output logic              frame_active_o,
  output logic              frame_done_o
);
  localparam int WORD_W = N_NEUR * DLY_W;

  logic              accept_w;
  logic              rd_valid_w;
  logic [WORD_W-1:0] delay_word_w;

  rfse_frame_ctrl #(.STEP_W(DLY_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .accept_o   (accept_w),
    .rd_valid_o (rd_valid_w),
    .active_o   (frame_active_o),
    .step_o     (step_o),
    .done_o     (frame_done_o)
  );

  rfse_delay_rom #(
    .IN_W(IN_W), .N_NEUR(N_NEUR), .DLY_W(DLY_W), .CENTRE0(CENTRE0),
    .SPACING(SPACING), .SLOPE_N(SLOPE_N), .SLOPE_D(SLOPE_D)
  ) u_rom (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (accept_w),
    .addr    (value_i),
    .rd_word (delay_word_w)
  );

  for (genvar k = 0; k < N_NEUR; k++) begin : g_nrn
    rfse_neuron #(.DLY_W(DLY_W)) u_nrn (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (rd_valid_w),
      .delay_i (delay_word_w[k*DLY_W +: DLY_W]),
      .tick_i  (frame_active_o),
      .spike_o (spike_o[k])
    );
  end

endmodule

// File: rtl/rfse_checker.sv
module rfse_checker #(
  parameter int N_NEUR = 16,
  parameter int STEP_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              rd_valid,
  input logic [N_NEUR-1:0] spike,
  input logic [STEP_W-1:0] step,
  input logic              active,
  input logic              done
);
  localparam logic [STEP_W-1:0] LAST = {STEP_W{1'b1}};

  logic [N_NEUR-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= '0;
    else if (rd_valid) seen_q <= '0;
    else seen_q <= seen_q | spike;
  end

  AST_READ_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rd_valid); // R2
  AST_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> (active && step == '0)); // R2
  AST_SINGLE_SPIKE: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ((spike & seen_q) == '0)); // R4
  AST_ALL_FIRED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((seen_q | spike) == '1)); // R4
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !done) |=> !rd_valid); // R7
  AST_DONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (active && step == LAST)); // R8
  AST_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !active); // R8
  AST_STEP_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (active && step != LAST) |=> (active && step == $past(step) + 1'b1)); // R9
  AST_SPIKE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (spike != '0) |-> active); // R10

endmodule

bind rf_spike_encoder rfse_checker #(.N_NEUR(N_NEUR), .STEP_W(DLY_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .accept   (accept_w),
  .rd_valid (rd_valid_w),
  .spike    (spike_o),
  .step     (step_o),
  .active   (frame_active_o),
  .done     (frame_done_o)
);

// File: tb/rf_spike_encoder_test.sv
`timescale 1ns/1ps
module rf_spike_encoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  value_i = '0;
  logic [15:0] spike_o;
  logic [3:0]  step_o;
  logic        frame_active_o;
  logic        frame_done_o;

  int n_chk = 0;
  int n_fail = 0;
  int fire_step [16];
  int fire_cnt  [16];

  always #2.5 clk = ~clk;

  rf_spike_encoder uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .value_i(value_i),
    .spike_o(spike_o), .step_o(step_o),
    .frame_active_o(frame_active_o), .frame_done_o(frame_done_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Field formula restated: nearest integer of 0.4*d, capped at 15.
  function automatic int expect_step(input int x, input int k);
    int d;
    int v;
    d = x - (37 + 17 * k);
    if (d < 0) d = -d;
    v = (4 * d + 5) / 10;
    return (v > 15) ? 15 : v;
  endfunction

  // Runs one frame. Optionally the strobe is held into the read cycle, and
  // a second strobe with another value is pulsed at step pulse_at.
  task automatic run_frame(input int x, input bit hold, input int pulse_at);
    for (int k = 0; k < 16; k++) begin fire_cnt[k] = 0; fire_step[k] = -1; end
    start_i = 1'b1; value_i = 8'(x);
    @(negedge clk);
    if (!hold) start_i = 1'b0;
    else value_i = 8'(x + 77);
    chk(frame_active_o == 1'b0, "R2 inactive during read", int'(frame_active_o), 0);
    @(negedge clk);
    start_i = 1'b0; value_i = 8'(x);
    for (int s = 0; s < 16; s++) begin
      chk(frame_active_o && step_o == 4'(s), "R9 step", int'(step_o), s);
      chk(frame_done_o == (s == 15), "R8 done on last step", int'(frame_done_o), int'(s == 15));
      for (int k = 0; k < 16; k++) if (spike_o[k]) begin
        fire_cnt[k]++;
        fire_step[k] = s;
      end
      start_i = (s == pulse_at);
      value_i = (s == pulse_at) ? 8'(x + 50) : 8'(x);
      @(negedge clk);
      start_i = 1'b0;
    end
    chk(frame_active_o == 1'b0, "R8 inactive after frame", int'(frame_active_o), 0);
    chk(spike_o == '0, "R10 no spike outside frame", int'(spike_o), 0);
  endtask

  task automatic check_neurons(input int x, input string tag);
    for (int k = 0; k < 16; k++) begin
      chk(fire_cnt[k] == 1, {tag, " R4 single spike"}, fire_cnt[k], 1);
      chk(fire_step[k] == expect_step(x, k), {tag, " R3 firing step"},
          fire_step[k], expect_step(x, k));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(spike_o == '0 && step_o == '0 && !frame_active_o && !frame_done_o,
        "R1 reset state", int'(spike_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(spike_o == '0 && step_o == '0 && !frame_active_o && !frame_done_o,
        "R1 idle after reset", int'(frame_active_o), 0);

    // Example value.
    run_frame(25, 1'b0, -1);
    chk(fire_step[0] == 5, "R5 neuron 0", fire_step[0], 5);
    chk(fire_step[1] == 12, "R5 neuron 1", fire_step[1], 12);
    for (int k = 2; k < 16; k++)
      chk(fire_step[k] == 15, "R5 other neurons at frame end", fire_step[k], 15);

    // Value outside every field.
    run_frame(0, 1'b0, -1);
    for (int k = 0; k < 16; k++)
      chk(fire_step[k] == 15 && fire_cnt[k] == 1, "R4 unactivated fires at 15", fire_step[k], 15);

    // Centre values.
    for (int k = 0; k < 13; k++) begin
      run_frame(37 + 17 * k, 1'b0, -1);
      chk(fire_step[k] == 0, "R6 centre fires at step 0", fire_step[k], 0);
    end

    // Busy strobes: held into the read cycle, and pulsed mid-frame.
    run_frame(25, 1'b1, 3);
    check_neurons(25, "R7 held+midframe");
    run_frame(140, 1'b0, 15);
    check_neurons(140, "R7 last-step strobe");
    repeat (20) begin
      chk(frame_active_o == 1'b0 && spike_o == '0, "R7 no extra frame", int'(frame_active_o), 0);
      @(negedge clk);
    end

    // Exhaustive sweep.
    for (int x = 0; x < 256; x++) begin
      run_frame(x, 1'b0, -1);
      check_neurons(x, "sweep");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule